// File: doc/BRIEF.md
# Two-Mode Priority Interrupt Controller

This block gathers a set of maskable interrupt request lines and one non-maskable request, chooses a single winner every clock, and presents it to a processor core. The winner is presented as a vector number and the matching vector address. Each maskable line passes through its own enable bit. The lines that pass are then filtered by one of two masking schemes, chosen by a two-bit mode input. In the flag scheme, one global mask bit blocks every maskable line at once. In the level scheme, each source carries a three-bit priority, and that priority is compared against a three-bit level mask supplied by the core.

The request to the core is a valid/ready channel. The block raises `req_valid_o` together with a vector and an address. It holds all three unchanged for as long as `req_ready_i` stays low; back-pressure can last any number of cycles, and a stronger request that turns up meanwhile does not replace the one on offer. A transfer takes place on a clock edge where both valid and ready are high. That transfer is the acknowledge. One cycle later the block pulses `grant_valid_o` with the level the core should load into its level mask. Valid then stays low for at least one cycle, which gives the serviced source time to withdraw its line before arbitration resumes. Mode, masks, enables and priority fields are plain inputs, so register decoding stays outside the block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `req_valid_o`, `grant_valid_o` and `mode_err_o` are all 0.
- R2: A maskable line whose `irq_en_i` bit is 0 never produces a request, whatever its priority and the masks.
- R3: With mode 0 (flag scheme), no maskable request is issued while `gmask_i` is 1. While `gmask_i` is 0, the lowest-indexed enabled pending line wins and the priority fields are ignored.
- R4: With mode 2 (level scheme), a line is eligible when its priority (bits [3i+2:3i] of `prio_i` for line i) is strictly greater than `lvl_mask_i`, or when it equals 7. Among eligible lines the highest priority wins, and a tie goes to the lowest index.
- R5: A rising edge on `nmi_i` is latched and wins over every maskable line, in any mode and under any mask. It is issued as vector `NMI_VEC` (default 7, address 0x001C) and the latch clears when that vector is acknowledged.
- R6: While `standby_i` is 1, an offered request is withdrawn on the next edge, a latched non-maskable request is discarded, and non-maskable edges are ignored.
- R7: Mode codes 1 and 3 are illegal. Under them no maskable request is issued (the non-maskable one still is), and `mode_err_o` is set and stays set until reset.
- R8: Line i is issued as vector `VEC_BASE`+i (default 80), and the address is the vector times four. Serial channel c event e is line 4c+e, with e = 0 receive error, 1 receive full, 2 transmit empty, 3 transmit end. For example, line 5 gives vector 85 at 0x0154, and line 11 gives vector 91 at 0x016C.
- R9: When the block is idle and a winner exists, `req_valid_o` rises on the next edge. Vector and address then stay stable until the transfer. After the transfer, valid is low for at least one cycle.
- R10: On the cycle after a transfer, `grant_valid_o` is 1 for one cycle. `grant_lvl_o` then carries the winner's priority in mode 2, 7 for the non-maskable request, and 0 for a maskable line in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Hardware standby; suppresses all requests |
| mode_i | input | 2 | Masking scheme: 0 flag, 2 level, 1/3 illegal |
| gmask_i | input | 1 | Global mask bit used in mode 0 |
| lvl_mask_i | input | 3 | Current level mask used in mode 2 |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| irq_i | input | NUM_SRC | Maskable request lines, level sensitive |
| irq_en_i | input | NUM_SRC | Per-line enable bits |
| prio_i | input | 3*NUM_SRC | Per-line priority, line i at [3i+2:3i] |
| req_valid_o | output | 1 | Request to core is on offer |
| req_ready_i | input | 1 | Core accepts the request (acknowledge) |
| req_vec_o | output | VEC_W | Winning vector number |
| req_addr_o | output | ADDR_W | Winning vector address (vector times four) |
| grant_valid_o | output | 1 | One-cycle pulse after a transfer |
| grant_lvl_o | output | 3 | Level granted with the pulse |
| mode_err_o | output | 1 | Sticky flag for an illegal mode code |

## Verification
A new request appears one clock edge after its inputs are applied to an idle block. A non-maskable edge is seen on the same edge it is sampled. The grant pulse and the drop of valid both appear one edge after the transfer. The next request can come no sooner than one further edge. The bench drives inputs one nanosecond after a rising edge and samples at the falling edge, so each check reads the value of the register stage it targets. A monitor compares each transfer against a queue of expected vectors, then checks the grant level and the low valid at the next falling edge. Suppression cases are checked by holding the stimulus for several cycles and observing that valid stays low.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int unsigned LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_TOP = 3'd7;

  typedef enum logic [1:0] {
    MODE_FLAG  = 2'd0,
    MODE_ILL_A = 2'd1,
    MODE_LEVEL = 2'd2,
    MODE_ILL_B = 2'd3
  } mask_mode_e;

  // Odd codes are the illegal ones.
  function automatic logic mode_is_legal(input logic [1:0] m);
    return !m[0];
  endfunction

endpackage

// File: rtl/irq_src_filter.sv
module irq_src_filter
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12
) (
  input  logic [1:0]           mode_i,
  input  logic                 gmask_i,
  input  logic [LVL_W-1:0]     lvl_mask_i,
  input  logic [NUM_SRC-1:0]   irq_i,
  input  logic [NUM_SRC-1:0]   irq_en_i,
  input  logic [LVL_W*NUM_SRC-1:0] prio_i,
  output logic [NUM_SRC-1:0]   elig_o,
  output logic [LVL_W*NUM_SRC-1:0] eff_prio_o
);

  mask_mode_e mode;
  logic       flag_mode;
  logic       level_mode;

  assign mode       = mask_mode_e'(mode_i);
  assign flag_mode  = (mode == MODE_FLAG);
  assign level_mode = (mode == MODE_LEVEL);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [LVL_W-1:0] p;
    logic             live;
    logic             above;

    assign p     = prio_i[LVL_W*g +: LVL_W];
    assign live  = irq_i[g] & irq_en_i[g];
    assign above = (p > lvl_mask_i) || (p == LVL_TOP);

    // Flag scheme: only the global bit matters. Level scheme: compare priority.
    assign elig_o[g] = live & ((flag_mode & ~gmask_i) | (level_mode & above));

    // In the flag scheme all lines rank equally, so the index decides.
    assign eff_prio_o[LVL_W*g +: LVL_W] = level_mode ? p : '0;
  end

endmodule

// File: rtl/irq_winner_sel.sv
module irq_winner_sel
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 12,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 80,
  parameter int unsigned NMI_VEC  = 7
) (
  input  logic [NUM_SRC-1:0]       elig_i,
  input  logic [LVL_W*NUM_SRC-1:0] eff_prio_i,
  input  logic                     nmi_req_i,
  output logic                     found_o,
  output logic                     is_nmi_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic [LVL_W-1:0]         lvl_o
);

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             any_mask;
  logic [LVL_W-1:0] best;
  logic [IDX_W-1:0] idx;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    any_mask = 1'b0;
    best     = '0;
    idx      = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (!any_mask || eff_prio_i[LVL_W*i +: LVL_W] >= best)) begin
        any_mask = 1'b1;
        best     = eff_prio_i[LVL_W*i +: LVL_W];
        idx      = IDX_W'(i);
      end
    end
  end

  always_comb begin
    found_o  = nmi_req_i | any_mask;
    is_nmi_o = nmi_req_i;
    if (nmi_req_i) begin
      vec_o = VEC_W'(NMI_VEC);
      lvl_o = LVL_TOP;
    end else begin
      vec_o = VEC_W'(VEC_BASE) + VEC_W'(idx);
      lvl_o = best;
    end
  end

endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_i,
  input  logic nmi_i,
  input  logic taken_i,
  output logic nmi_req_o
);

  logic nmi_q;
  logic pend_q;
  logic rise;

  assign rise      = nmi_i & ~nmi_q;
  assign nmi_req_o = ~standby_i & (pend_q | rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      if (standby_i) begin
        pend_q <= 1'b0;
      end else begin
        // A fresh edge survives an acknowledge of the previous one.
        pend_q <= rise | (pend_q & ~taken_i);
      end
    end
  end

endmodule

// File: rtl/irq_req_stage.sv
module irq_req_stage
  import irq_prio_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              found_i,
  input  logic              is_nmi_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              grant_valid_o,
  output logic [LVL_W-1:0]  grant_lvl_o,
  output logic              nmi_taken_o
);

  logic             valid_q;
  logic [LVL_W-1:0] held_lvl_q;
  logic             held_nmi_q;
  logic             xfer;

  assign xfer        = valid_q & ready_i;
  assign nmi_taken_o = xfer & held_nmi_q;
  assign valid_o     = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q       <= 1'b0;
      vec_o         <= '0;
      addr_o        <= '0;
      held_lvl_q    <= '0;
      held_nmi_q    <= 1'b0;
      grant_valid_o <= 1'b0;
      grant_lvl_o   <= '0;
    end else if (standby_i) begin
      valid_q       <= 1'b0;
      grant_valid_o <= 1'b0;
    end else begin
      grant_valid_o <= xfer;
      if (xfer) begin
        grant_lvl_o <= held_lvl_q;
      end
      if (valid_q) begin
        // Hold everything until the core takes it.
        if (ready_i) begin
          valid_q <= 1'b0;
        end
      end else if (found_i) begin
        valid_q    <= 1'b1;
        vec_o      <= vec_i;
        addr_o     <= ADDR_W'({vec_i, 2'b00});
        held_lvl_q <= lvl_i;
        held_nmi_q <= is_nmi_i;
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 12,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 80,
  parameter int unsigned NMI_VEC  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     standby_i,
  input  logic [1:0]               mode_i,
  input  logic                     gmask_i,
  input  logic [2:0]               lvl_mask_i,
  input  logic                     nmi_i,
  input  logic [NUM_SRC-1:0]       irq_i,
  input  logic [NUM_SRC-1:0]       irq_en_i,
  input  logic [3*NUM_SRC-1:0]     prio_i,
  output logic                     req_valid_o,
  input  logic                     req_ready_i,
  output logic [VEC_W-1:0]         req_vec_o,
  output logic [ADDR_W-1:0]        req_addr_o,
  output logic                     grant_valid_o,
  output logic [2:0]               grant_lvl_o,
  output logic                     mode_err_o
);

  logic [NUM_SRC-1:0]       elig;
  logic [LVL_W*NUM_SRC-1:0] eff_prio;
  logic                     nmi_req;
  logic                     nmi_taken;
  logic                     win_found;
  logic                     win_nmi;
  logic [VEC_W-1:0]         win_vec;
  logic [LVL_W-1:0]         win_lvl;

  irq_src_filter #(.NUM_SRC(NUM_SRC)) u_filter (
    .mode_i     (mode_i),
    .gmask_i    (gmask_i),
    .lvl_mask_i (lvl_mask_i),
    .irq_i      (irq_i),
    .irq_en_i   (irq_en_i),
    .prio_i     (prio_i),
    .elig_o     (elig),
    .eff_prio_o (eff_prio)
  );

  irq_nmi_latch u_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .nmi_i     (nmi_i),
    .taken_i   (nmi_taken),
    .nmi_req_o (nmi_req)
  );

  irq_winner_sel #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .NMI_VEC  (NMI_VEC)
  ) u_sel (
    .elig_i     (elig),
    .eff_prio_i (eff_prio),
    .nmi_req_i  (nmi_req),
    .found_o    (win_found),
    .is_nmi_o   (win_nmi),
    .vec_o      (win_vec),
    .lvl_o      (win_lvl)
  );

  irq_req_stage #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_stage (
    .clk           (clk),
    .rst_n         (rst_n),
    .standby_i     (standby_i),
    .found_i       (win_found),
    .is_nmi_i      (win_nmi),
    .vec_i         (win_vec),
    .lvl_i         (win_lvl),
    .ready_i       (req_ready_i),
    .valid_o       (req_valid_o),
    .vec_o         (req_vec_o),
    .addr_o        (req_addr_o),
    .grant_valid_o (grant_valid_o),
    .grant_lvl_o   (grant_lvl_o),
    .nmi_taken_o   (nmi_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_err_o <= 1'b0;
    end else if (!mode_is_legal(mode_i)) begin
      mode_err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NMI_VEC = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby_i,
  input logic [1:0]        mode_i,
  input logic              gmask_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [VEC_W-1:0]  req_vec_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              grant_valid_o,
  input logic [2:0]        grant_lvl_o,
  input logic              mode_err_o
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || standby_i)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_vec_o) && $stable(req_addr_o)));

  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n || standby_i)
    (req_valid_o && req_ready_i) |=> !req_valid_o);

  p_grant_r10: assert property (@(posedge clk) disable iff (!rst_n || standby_i)
    (req_valid_o && req_ready_i) |=> grant_valid_o);

  p_nmi_lvl_r10: assert property (@(posedge clk) disable iff (!rst_n || standby_i)
    (req_valid_o && req_ready_i && req_vec_o == VEC_W'(NMI_VEC)) |=> (grant_lvl_o == 3'd7));

  p_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_addr_o == ADDR_W'({req_vec_o, 2'b00})));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |=> mode_err_o);

  p_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid_o && mode_i[0]) |=> (!req_valid_o || req_vec_o == VEC_W'(NMI_VEC)));

  p_gmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid_o && mode_i == 2'd0 && gmask_i) |=> (!req_valid_o || req_vec_o == VEC_W'(NMI_VEC)));

  p_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> !req_valid_o);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .VEC_W   (VEC_W),
  .ADDR_W  (ADDR_W),
  .NMI_VEC (NMI_VEC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .standby_i     (standby_i),
  .mode_i        (mode_i),
  .gmask_i       (gmask_i),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_vec_o     (req_vec_o),
  .req_addr_o    (req_addr_o),
  .grant_valid_o (grant_valid_o),
  .grant_lvl_o   (grant_lvl_o),
  .mode_err_o    (mode_err_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          standby_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          gmask_i = 1'b0;
  logic [2:0]    lvl_mask_i = 3'd0;
  logic          nmi_i = 1'b0;
  logic [N-1:0]  irq_i = '0;
  logic [N-1:0]  irq_en_i = '0;
  logic [3*N-1:0] prio_i = '0;
  logic          req_valid_o;
  logic          req_ready_i = 1'b0;
  logic [7:0]    req_vec_o;
  logic [15:0]   req_addr_o;
  logic          grant_valid_o;
  logic [2:0]    grant_lvl_o;
  logic          mode_err_o;

  always #2 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .mode_i(mode_i),
    .gmask_i(gmask_i), .lvl_mask_i(lvl_mask_i), .nmi_i(nmi_i),
    .irq_i(irq_i), .irq_en_i(irq_en_i), .prio_i(prio_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_vec_o(req_vec_o), .req_addr_o(req_addr_o),
    .grant_valid_o(grant_valid_o), .grant_lvl_o(grant_lvl_o),
    .mode_err_o(mode_err_o)
  );

  typedef struct {
    logic [7:0]  vec;
    logic [15:0] addr;
    logic [2:0]  lvl;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   grant_due = 1'b0;
  exp_t cur;
  bit   done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_prio(input int i, input logic [2:0] p);
    prio_i[3*i +: 3] = p;
  endtask

  task automatic push_exp(input logic [7:0] v, input logic [2:0] l, input string req);
    exp_t e;
    e.vec = v; e.addr = {6'd0, v, 2'b00}; e.lvl = l; e.req = req;
    exp_q.push_back(e);
  endtask

  // Wait for an offered request, then accept it for one cycle.
  task automatic serve();
    bit seen = 1'b0;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      if (req_valid_o) seen = 1'b1;
    end
    if (!seen) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, "request timeout", 32'(req_valid_o), 32'd1);
      step(1);
    end else begin
      step(1);
      req_ready_i = 1'b1;
      step(1);
      req_ready_i = 1'b0;
    end
  endtask

  // Monitor: compares each transfer, then the grant and the gap one cycle later.
  always @(negedge clk) begin
    if (grant_due) begin
      grant_due = 1'b0;
      check("R10", "grant valid", 32'(grant_valid_o), 32'd1);
      check("R10", "grant level", 32'(grant_lvl_o), 32'(cur.lvl));
      check("R9", "valid gap after transfer", 32'(req_valid_o), 32'd0);
    end
    if (rst_n && req_valid_o && req_ready_i) begin
      if (exp_q.size() == 0) begin
        check("R9", "unexpected transfer", 32'(req_vec_o), 32'hFFFF);
      end else begin
        cur = exp_q.pop_front();
        check(cur.req, "vector", 32'(req_vec_o), 32'(cur.vec));
        check("R8", "address", 32'(req_addr_o), 32'(cur.addr));
        grant_due = 1'b1;
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    @(negedge clk);
    check("R1", "valid after reset", 32'(req_valid_o), 32'd0);
    check("R1", "grant after reset", 32'(grant_valid_o), 32'd0);
    check("R1", "mode_err after reset", 32'(mode_err_o), 32'd0);

    // R3: flag scheme, lowest index wins even with higher priority elsewhere.
    step(1);
    mode_i = 2'd0; irq_en_i = '1;
    set_prio(5, 3'd6); set_prio(2, 3'd1);
    irq_i[5] = 1'b1; irq_i[2] = 1'b1;
    push_exp(8'd82, 3'd0, "R3");
    serve();
    irq_i[2] = 1'b0;
    push_exp(8'd85, 3'd0, "R8");   // channel 1 receive full
    serve();
    irq_i = '0;

    // R2: disabled line stays silent.
    irq_en_i = '0; irq_en_i[4] = 1'b1;
    irq_i[3] = 1'b1;
    step(5);
    check("R2", "disabled line silent", 32'(req_valid_o), 32'd0);
    irq_i = '0; irq_en_i = '1;

    // R3: global mask blocks, then release.
    gmask_i = 1'b1; irq_i[0] = 1'b1;
    step(5);
    check("R3", "gmask blocks", 32'(req_valid_o), 32'd0);
    gmask_i = 1'b0;
    push_exp(8'd80, 3'd0, "R3");
    serve();
    irq_i = '0;

    // R4: level scheme, highest priority, tie to lowest index.
    mode_i = 2'd2; lvl_mask_i = 3'd2; gmask_i = 1'b1;
    prio_i = '0;
    set_prio(1, 3'd3); set_prio(4, 3'd5); set_prio(9, 3'd5);
    irq_i[1] = 1'b1; irq_i[4] = 1'b1; irq_i[9] = 1'b1;
    push_exp(8'd84, 3'd5, "R4");
    serve();
    irq_i[4] = 1'b0;
    push_exp(8'd89, 3'd5, "R4");
    serve();
    irq_i = '0;

    // R4: equal to mask is not enough; level 7 always passes.
    lvl_mask_i = 3'd5; set_prio(6, 3'd5); irq_i[6] = 1'b1;
    step(5);
    check("R4", "priority equal to mask blocked", 32'(req_valid_o), 32'd0);
    irq_i = '0;
    lvl_mask_i = 3'd7; set_prio(11, 3'd7); irq_i[11] = 1'b1;
    push_exp(8'd91, 3'd7, "R4");
    serve();
    irq_i = '0;

    // R5: NMI pulse beats a pending level-7 line.
    irq_i[11] = 1'b1; nmi_i = 1'b1;
    push_exp(8'd7, 3'd7, "R5");
    step(1);
    nmi_i = 1'b0;
    serve();
    push_exp(8'd91, 3'd7, "R5");
    serve();
    irq_i = '0;
    step(4);
    check("R5", "NMI latch cleared", 32'(req_valid_o), 32'd0);

    // R9: held request stays stable under back-pressure.
    mode_i = 2'd0; gmask_i = 1'b0;
    irq_i[7] = 1'b1;
    step(3);
    irq_i[0] = 1'b1;
    step(3);
    @(negedge clk);
    check("R9", "held vector stable", 32'(req_vec_o), 32'd87);
    check("R9", "held valid", 32'(req_valid_o), 32'd1);
    push_exp(8'd87, 3'd0, "R9");
    serve();
    irq_i[7] = 1'b0;
    push_exp(8'd80, 3'd0, "R9");
    serve();
    irq_i = '0;

    // R6: standby withdraws a request and ignores NMI edges.
    irq_i[3] = 1'b1;
    step(3);
    standby_i = 1'b1;
    irq_i = '0;
    step(1);
    @(negedge clk);
    check("R6", "standby withdraws", 32'(req_valid_o), 32'd0);
    step(1);
    nmi_i = 1'b1;
    step(1);
    nmi_i = 1'b0;
    step(2);
    standby_i = 1'b0;
    step(5);
    check("R6", "NMI ignored in standby", 32'(req_valid_o), 32'd0);

    // R7: illegal modes, sticky flag, NMI still served.
    mode_i = 2'd1; irq_i[0] = 1'b1;
    step(5);
    check("R7", "illegal mode blocks", 32'(req_valid_o), 32'd0);
    check("R7", "mode_err set", 32'(mode_err_o), 32'd1);
    mode_i = 2'd3; nmi_i = 1'b1;
    push_exp(8'd7, 3'd7, "R7");
    step(1);
    nmi_i = 1'b0;
    serve();
    mode_i = 2'd0;
    push_exp(8'd80, 3'd0, "R7");
    serve();
    irq_i = '0;
    step(2);
    check("R7", "mode_err sticky", 32'(mode_err_o), 32'd1);

    step(3);
    check("R9", "scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule